// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

The block holds two 8-bit up counters, each paired with an 8-bit compare register. In split mode each counter is a separate interval timer. It advances on its own count tick while its run bit is set. On a tick where its count equals its compare value, it returns to zero and pulses that channel's interrupt. In chained mode the two counters form one 16-bit timer. Channel 0 supplies the low byte. Channel 1 supplies the high byte and only advances when the low byte rolls over.

Software loads the compare registers through two byte-wide write strobes that share one data bus. Compare values may be changed while the timer is counting. In chained mode the 16-bit compare only becomes active once a low-byte write has been followed by a high-byte write. A separate toggle pulse comes out in the same cycle as the selected match. It is meant to drive an external toggle flip-flop.

Top module: `dual_interval_timer`

## Requirements
- R1: In split mode, a tick on a running channel whose count equals its compare value clears that count to zero. The same tick makes `irq_o[i]` (bit index = channel) high for the following cycle, so the match period is compare value + 1 ticks.
- R2: A counter changes only on cycles where both its tick and its run bit are high. Ticks on a stopped channel produce no interrupt.
- R3: While a channel's run bit is low, its counter is held at zero. After the run bit is set again, counting restarts from zero.
- R4: A compare value written below the current count produces no match until the counter has passed 255, wrapped to 0 and climbed to the new value.
- R5: A compare value written above the current count applies to the interval already in progress.
- R6: With `mode_i` = 1 (chained; 0 = split), channel 0 is the low byte and uses `tick_i[0]` and `run_i[0]`. The high byte advances only when the low byte goes from 255 to 0. A match needs all 16 bits equal and clears both bytes. It pulses `irq_o[1]` only, and `irq_o[0]` stays low.
- R7: Compare arming follows the write order. A low-byte write disarms the 16-bit compare and marks a pending low byte. A high-byte write arms the compare only if a low byte is pending. A high-byte write with nothing pending leaves the compare disarmed. Writing both bytes in the same cycle arms it. `wr_lo_i` loads channel 0's compare and `wr_hi_i` loads channel 1's.
- R8: `tgl_o` pulses in the same cycle as the interrupt of the selected source. In split mode `tgl_src_i` = 0 selects channel 0 and 1 selects channel 1. In chained mode `tgl_o` follows the 16-bit match.
- R9: Synchronous reset zeroes both counters and both compare registers, disarms the 16-bit compare, and drives all outputs low.
- R10: In split mode the two channels are independent: each runs on its own tick, run bit and compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 2 | Count-enable tick per channel |
| run_i | input | 2 | Run bit per channel |
| mode_i | input | 1 | 0 = two 8-bit timers, 1 = one 16-bit timer |
| tgl_src_i | input | 1 | Toggle source in split mode (0 = channel 0, 1 = channel 1) |
| wr_lo_i | input | 1 | Write strobe for channel 0 / low-byte compare |
| wr_hi_i | input | 1 | Write strobe for channel 1 / high-byte compare |
| wr_data_i | input | 8 | Compare write data |
| irq_o | output | 2 | One-cycle interrupt pulse per channel |
| tgl_o | output | 1 | One-cycle pulse for an external toggle flip-flop |

## Verification
The chained-mode assertions assume that `mode_i` only changes while both run bits are low. The stimulus switches mode only after stopping both channels, and it also keeps the toggle source steady across a run. The assertions that pair each interrupt with an earlier tick assume ticks arrive as level-sampled strobes. The bench drives them as such on the falling edge. It steps through irregular tick patterns, live compare rewrites and every arming order.

// File: rtl/ditmr_pkg.sv
package ditmr_pkg;

    localparam int unsigned DEF_CW  = 8;
    localparam int unsigned NUM_CH  = 2;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_CHAIN = 1'b1
    } tmode_e;

    // per-counter control produced by the match/route logic
    typedef struct packed {
        logic run;   // counter allowed to hold a non-zero value
        logic step;  // advance by one this cycle
        logic clr;   // match clear this cycle (wins over step)
    } cnt_ctl_t;

    function automatic logic chain_hit(input logic step, input logic armed,
                                       input logic [NUM_CH-1:0] eq);
        return step & armed & (&eq);
    endfunction

endpackage

// File: rtl/ditmr_chan.sv
module ditmr_chan
    import ditmr_pkg::*;
#(
    parameter int unsigned CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_ctl_t      ctl,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] cnt_o,
    output logic          eq_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!ctl.run || ctl.clr) begin
            cnt_q <= '0;
        end else if (ctl.step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (wr_en) begin
            cmp_q <= wr_data;
        end
    end

    assign eq_o  = (cnt_q == cmp_q);
    assign cnt_o = cnt_q;

endmodule

// File: rtl/ditmr_arm.sv
module ditmr_arm (
    input  logic clk,
    input  logic rst,
    input  logic wr_lo,
    input  logic wr_hi,
    output logic armed_o
);

    logic armed_q;
    logic lo_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            lo_pend_q <= 1'b0;
        end else begin
            case ({wr_hi, wr_lo})
                2'b11: begin
                    armed_q   <= 1'b1;
                    lo_pend_q <= 1'b0;
                end
                2'b01: begin
                    armed_q   <= 1'b0;
                    lo_pend_q <= 1'b1;
                end
                2'b10: begin
                    armed_q   <= lo_pend_q;
                    lo_pend_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign armed_o = armed_q;

endmodule

// File: rtl/ditmr_ctl.sv
module ditmr_ctl
    import ditmr_pkg::*;
#(
    parameter int unsigned CW = DEF_CW
) (
    input  logic                mode,
    input  logic                tgl_src,
    input  logic [NUM_CH-1:0]   tick,
    input  logic [NUM_CH-1:0]   run,
    input  logic [NUM_CH-1:0]   eq,
    input  logic [CW-1:0]       cnt_lo,
    input  logic                armed,
    output cnt_ctl_t [NUM_CH-1:0] ctl,
    output logic [NUM_CH-1:0]   fire,
    output logic                tgl_fire
);

    logic lo_step;
    logic hit;

    always_comb begin
        ctl      = '0;
        fire     = '0;
        tgl_fire = 1'b0;
        lo_step  = tick[0] & run[0];
        hit      = 1'b0;
        if (tmode_e'(mode) == MODE_SPLIT) begin
            for (int i = 0; i < NUM_CH; i++) begin
                ctl[i].run  = run[i];
                ctl[i].step = tick[i] & run[i];
                fire[i]     = tick[i] & run[i] & eq[i];
                ctl[i].clr  = fire[i];
            end
            tgl_fire = tgl_src ? fire[1] : fire[0];
        end else begin
            hit         = chain_hit(lo_step, armed, eq);
            ctl[0].run  = run[0];
            ctl[1].run  = run[0];
            ctl[0].step = lo_step;
            ctl[1].step = lo_step & (&cnt_lo);
            ctl[0].clr  = hit;
            ctl[1].clr  = hit;
            fire[1]     = hit;
            tgl_fire    = hit;
        end
    end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import ditmr_pkg::*;
#(
    parameter int unsigned CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    tick_i,
    input  logic [1:0]    run_i,
    input  logic          mode_i,
    input  logic          tgl_src_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [CW-1:0] wr_data_i,
    output logic [1:0]    irq_o,
    output logic          tgl_o
);

    cnt_ctl_t [NUM_CH-1:0]         ctl;
    logic [NUM_CH-1:0][CW-1:0]     cnt;
    logic [NUM_CH-1:0]             eq;
    logic [NUM_CH-1:0]             fire;
    logic [NUM_CH-1:0]             wr_en;
    logic                          tgl_fire;
    logic                          armed;
    logic [NUM_CH-1:0]             irq_q;
    logic                          tgl_q;

    assign wr_en = {wr_hi_i, wr_lo_i};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ditmr_chan #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl[g]),
            .wr_en   (wr_en[g]),
            .wr_data (wr_data_i),
            .cnt_o   (cnt[g]),
            .eq_o    (eq[g])
        );
    end

    ditmr_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (wr_lo_i),
        .wr_hi   (wr_hi_i),
        .armed_o (armed)
    );

    ditmr_ctl #(.CW(CW)) u_ctl (
        .mode     (mode_i),
        .tgl_src  (tgl_src_i),
        .tick     (tick_i),
        .run      (run_i),
        .eq       (eq),
        .cnt_lo   (cnt[0]),
        .armed    (armed),
        .ctl      (ctl),
        .fire     (fire),
        .tgl_fire (tgl_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            tgl_q <= 1'b0;
        end else begin
            irq_q <= fire;
            tgl_q <= tgl_fire;
        end
    end

    assign irq_o = irq_q;
    assign tgl_o = tgl_q;

endmodule

// File: rtl/ditmr_chk.sv
module ditmr_chk #(
    parameter int unsigned CW = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         tick_i,
    input logic [1:0]         run_i,
    input logic               mode_i,
    input logic [1:0]         irq_o,
    input logic               tgl_o,
    input logic [1:0][CW-1:0] cnt,
    input logic               armed
);

    AST_IRQ0_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        irq_o[0] |-> $past(tick_i[0] && run_i[0])); // R2

    AST_STOP_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !run_i[0]) |=> (cnt[0] == '0)); // R3

    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && irq_o[0]) |-> (cnt[0] == '0)); // R1

    AST_CHAIN_LO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode_i && $past(mode_i)) |-> !irq_o[0]); // R6

    AST_CHAIN_HI_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mode_i && $past(mode_i) && run_i[0] && $past(run_i[0]) &&
         (cnt[1] != $past(cnt[1]))) |-> (cnt[0] == '0)); // R6

    AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_i && !armed) |=> !irq_o[1]); // R7

    AST_TGL_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
        tgl_o |-> (irq_o != 2'b00)); // R8

endmodule

bind dual_interval_timer ditmr_chk #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .run_i  (run_i),
    .mode_i (mode_i),
    .irq_o  (irq_o),
    .tgl_o  (tgl_o),
    .cnt    (cnt),
    .armed  (armed)
);

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/1ps
module dual_interval_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] tick = 2'b00;
    logic [1:0] run = 2'b00;
    logic       mode = 1'b0;
    logic       tsrc = 1'b0;
    logic       wlo = 1'b0;
    logic       whi = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [1:0] irq;
    logic       tgl;

    int    total = 0;
    int    bad = 0;
    string phase = "R9";
    bit    mon_on = 1'b0;
    int    n_irq0 = 0, n_irq1 = 0, n_tgl = 0;

    // reference model state
    int m_c0 = 0, m_c1 = 0, m_k0 = 0, m_k1 = 0;
    bit m_arm = 0, m_pend = 0;
    bit e_irq0 = 0, e_irq1 = 0, e_tgl = 0;

    dual_interval_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .run_i     (run),
        .mode_i    (mode),
        .tgl_src_i (tsrc),
        .wr_lo_i   (wlo),
        .wr_hi_i   (whi),
        .wr_data_i (wd),
        .irq_o     (irq),
        .tgl_o     (tgl)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        bit f0, f1;
        int n0, n1;
        f0 = 0; f1 = 0; n0 = m_c0; n1 = m_c1;
        if (rst) begin
            m_c0 = 0; m_c1 = 0; m_k0 = 0; m_k1 = 0;
            m_arm = 0; m_pend = 0;
            e_irq0 = 0; e_irq1 = 0; e_tgl = 0;
        end else begin
            if (!mode) begin
                if (!run[0]) n0 = 0;
                else if (tick[0]) begin
                    if (m_c0 == m_k0) begin n0 = 0; f0 = 1; end
                    else n0 = (m_c0 + 1) % 256;
                end
                if (!run[1]) n1 = 0;
                else if (tick[1]) begin
                    if (m_c1 == m_k1) begin n1 = 0; f1 = 1; end
                    else n1 = (m_c1 + 1) % 256;
                end
            end else begin
                if (!run[0]) begin n0 = 0; n1 = 0; end
                else if (tick[0]) begin
                    if (m_arm && m_c0 == m_k0 && m_c1 == m_k1) begin
                        n0 = 0; n1 = 0; f1 = 1;
                    end else begin
                        n0 = (m_c0 + 1) % 256;
                        if (m_c0 == 255) n1 = (m_c1 + 1) % 256;
                    end
                end
            end
            m_c0 = n0; m_c1 = n1;
            e_irq0 = f0; e_irq1 = f1;
            e_tgl = mode ? f1 : (tsrc ? f1 : f0);
            if (wlo) m_k0 = wd;
            if (whi) m_k1 = wd;
            if (wlo && whi) begin m_arm = 1; m_pend = 0; end
            else if (wlo) begin m_arm = 0; m_pend = 1; end
            else if (whi) begin m_arm = m_pend; m_pend = 0; end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            check(irq == {e_irq1, e_irq0}, {phase, " irq"}, irq, {e_irq1, e_irq0});
            check(tgl == e_tgl, {phase, " tgl"}, tgl, e_tgl);
            if (irq[0]) n_irq0++;
            if (irq[1]) n_irq1++;
            if (tgl) n_tgl++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet_zero();
        tick = 2'b00;
        cyc(2);
        n_irq0 = 0; n_irq1 = 0; n_tgl = 0;
    endtask

    task automatic wr(input bit lo, input bit hi, input logic [7:0] v);
        wd = v; wlo = lo; whi = hi;
        @(negedge clk);
        wlo = 0; whi = 0;
    endtask

    task automatic ticks0(input int n);
        tick[0] = 1'b1;
        cyc(n);
        tick[0] = 1'b0;
        cyc(2);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R9: outputs idle after reset
        check(irq == 2'b00, "R9 irq after reset", irq, 0);
        check(tgl == 1'b0, "R9 tgl after reset", tgl, 0);
        mon_on = 1'b1;
        // R9: compare reset to zero, so the first tick matches
        run = 2'b01;
        quiet_zero();
        ticks0(1);
        check(n_irq0 == 1, "R9 zero compare first tick", n_irq0, 1);

        // R1, R10: two independent periods
        phase = "R10";
        run = 2'b00;
        wr(1, 0, 8'd4);
        wr(0, 1, 8'd2);
        quiet_zero();
        run = 2'b11; tick = 2'b11;
        cyc(60);
        quiet_zero_keep();
        check(n_irq0 == 12, "R1 period ch0", n_irq0, 12);
        check(n_irq1 == 20, "R10 period ch1", n_irq1, 20);

        // R2: stopped channel ignores ticks, sparse ticks
        phase = "R2";
        run = 2'b00;
        quiet_zero();
        tick = 2'b11;
        cyc(20);
        tick = 2'b00;
        cyc(2);
        check(n_irq0 + n_irq1 == 0, "R2 stopped ticks", n_irq0 + n_irq1, 0);
        wr(1, 0, 8'd2);
        run = 2'b01;
        quiet_zero();
        for (int i = 0; i < 30; i++) begin
            tick[0] = (i % 2 == 0);
            @(negedge clk);
        end
        tick = 2'b00;
        cyc(2);
        check(n_irq0 == 5, "R2 sparse ticks", n_irq0, 5);

        // R3: stop clears, restart from zero
        phase = "R3";
        run = 2'b00;
        wr(1, 0, 8'd9);
        run = 2'b01;
        quiet_zero();
        ticks0(7);
        run[0] = 1'b0; tick[0] = 1'b1;
        cyc(1);
        run[0] = 1'b1; tick[0] = 1'b0;
        cyc(1);
        ticks0(9);
        check(n_irq0 == 0, "R3 no match before restart interval", n_irq0, 0);
        ticks0(1);
        check(n_irq0 == 1, "R3 match after restart interval", n_irq0, 1);

        // R4: lower compare written live wraps
        phase = "R4";
        run = 2'b00;
        wr(1, 0, 8'd200);
        run = 2'b01;
        quiet_zero();
        ticks0(100);
        wr(1, 0, 8'd50);
        ticks0(150);
        check(n_irq0 == 0, "R4 no match below count", n_irq0, 0);
        ticks0(56);
        check(n_irq0 == 0, "R4 still waiting after wrap", n_irq0, 0);
        ticks0(1);
        check(n_irq0 == 1, "R4 match after wrap", n_irq0, 1);

        // R5: higher compare written live extends interval
        phase = "R5";
        run = 2'b00;
        wr(1, 0, 8'd10);
        run = 2'b01;
        quiet_zero();
        ticks0(5);
        wr(1, 0, 8'd30);
        ticks0(25);
        check(n_irq0 == 0, "R5 old compare passed silently", n_irq0, 0);
        ticks0(1);
        check(n_irq0 == 1, "R5 new compare matched", n_irq0, 1);

        // R6, R7: chained mode and arming
        phase = "R7";
        run = 2'b00;
        cyc(1);
        mode = 1'b1;
        wr(1, 0, 8'd3);
        run = 2'b01;
        quiet_zero();
        ticks0(600);
        check(n_irq1 == 0, "R7 low-only write stays unarmed", n_irq1, 0);
        run = 2'b00;
        wr(0, 1, 8'd1);
        run = 2'b01;
        phase = "R6";
        quiet_zero();
        ticks0(259);
        check(n_irq1 == 0, "R6 no match below 16-bit compare", n_irq1, 0);
        ticks0(1);
        check(n_irq1 == 1, "R6 16-bit match", n_irq1, 1);
        check(n_irq0 == 0, "R6 low channel quiet", n_irq0, 0);
        check(n_tgl == 1, "R8 toggle follows 16-bit match", n_tgl, 1);
        phase = "R7";
        wr(0, 1, 8'd1);
        run = 2'b00;
        cyc(1);
        run = 2'b01;
        quiet_zero();
        ticks0(600);
        check(n_irq1 == 0, "R7 high-only write disarms", n_irq1, 0);
        run = 2'b00;
        wr(1, 1, 8'd2);
        run = 2'b01;
        quiet_zero();
        ticks0(514);
        check(n_irq1 == 0, "R7 simultaneous write before match", n_irq1, 0);
        ticks0(1);
        check(n_irq1 == 1, "R7 simultaneous write arms", n_irq1, 1);

        // R8: toggle source select in split mode
        phase = "R8";
        run = 2'b00;
        cyc(1);
        mode = 1'b0;
        wr(1, 0, 8'd1);
        wr(0, 1, 8'd2);
        tsrc = 1'b1;
        run = 2'b11;
        quiet_zero();
        tick = 2'b11;
        cyc(30);
        quiet_zero_keep();
        check(n_tgl == 10, "R8 toggle from ch1", n_tgl, 10);
        run = 2'b00;
        cyc(1);
        tsrc = 1'b0;
        run = 2'b11;
        quiet_zero();
        tick = 2'b11;
        cyc(30);
        quiet_zero_keep();
        check(n_tgl == 15, "R8 toggle from ch0", n_tgl, 15);

        mon_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // stop ticking and let the last pulse land without clearing counts
    task automatic quiet_zero_keep();
        tick = 2'b00;
        cyc(2);
    endtask

endmodule